// File: doc/BRIEF.md
# Serial-Loaded Synthesizer Control Register Bank

This block is the programming port of a clock-synthesizer control section. A host writes it over three wires: a serial clock, a serial data line and a load strobe. Each frame is 24 bits long and is sent most-significant bit first. When the load strobe rises, the frame is copied into one of four control latches. The two lowest bits of the frame pick the latch. The block drives the fields of those latches in parallel to the divider and charge-pump logic around it.

The serial pins and the chip-enable pin are asynchronous to the system clock, so the block first passes them through a synchronizer. The block then finds the rising edges of the serial clock and of the load strobe in the system-clock domain. The rest of the chip is told that the block is powered up only when two conditions hold: chip enable is high, and the power-down bit in the function latch is clear. The charge-pump high-impedance control is the inverse of that power-up indication.

Top module: `sercfg_bank`

## Requirements
- R1: After reset, every latch output is zero. With chip enable held high, pwr_up is 1 and cp_hiz is 0.
- R2: Data is shifted in on each rising edge of ser_clk, most-significant bit first. A load transfers the 24 bits shifted in most recently, so any earlier extra bits are dropped.
- R3: A load with control bits [1:0] = 00 sets ref_div to frame bits [15:2] and ref_ctl to frame bits [23:16].
- R4: A load with control bits 01 sets n_div to frame bits [14:2] and n_ctl to frame bits [23:15].
- R5: A load with control bits 10 sets func_word to frame bits [23:2] and leaves init_word unchanged.
- R6: A load with control bits 11 sets both init_word and func_word to frame bits [23:2].
- R7: A transfer happens only on a rising edge of ser_le. Serial clock edges that arrive while ser_le is held high leave every latch output unchanged.
- R8: When func_word bit 1 (frame bit 3) is 1, pwr_up is 0 and cp_hiz is 1. Clearing that bit restores pwr_up to 1.
- R9: When chip_en is low, pwr_up is 0 and cp_hiz is 1 whatever the power-down bit holds, and all latch values are kept.
- R10: A latch keeps its value across loads addressed to the other latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; its rising edge commits the frame |
| chip_en | input | 1 | Chip enable; low forces power-down |
| ref_div | output | 14 | Reference divider count |
| ref_ctl | output | 8 | Reference latch control bits |
| n_div | output | 13 | N divider count |
| n_ctl | output | 9 | N latch control bits |
| func_word | output | 22 | Function latch payload (bit 1 = power-down) |
| init_word | output | 22 | Initialization latch payload |
| pwr_up | output | 1 | Powered-up indication |
| cp_hiz | output | 1 | Charge-pump high-impedance control |

## Verification
If the shift register is off by one bit, or the control bits are decoded wrongly, the wrong latch field changes within about three system-clock cycles of the load strobe. The bench catches this because it compares all six latch outputs after every frame. If a latch is updated without a load strobe, or a frame addressed to one latch writes another, a value that was already correct changes at the next comparison. A fault in the power gating shows up on pwr_up and cp_hiz two to three cycles after chip_en or the power-down bit changes.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

    localparam int WORD_W    = 24;
    localparam int SEL_W     = 2;
    localparam int PAY_W     = WORD_W - SEL_W;
    localparam int REF_W     = 14;
    localparam int REF_CTL_W = PAY_W - REF_W;
    localparam int N_W       = 13;
    localparam int N_CTL_W   = PAY_W - N_W;
    localparam int PD_POS    = 1;

    typedef enum logic [SEL_W-1:0] {
        SEL_REF  = 2'b00,
        SEL_NDIV = 2'b01,
        SEL_FUNC = 2'b10,
        SEL_INIT = 2'b11
    } sel_e;

    typedef struct packed {
        logic [PAY_W-1:0] pay;
        sel_e             sel;
    } frame_t;

    typedef struct packed {
        logic [REF_CTL_W-1:0] ctl;
        logic [REF_W-1:0]     div;
    } ref_t;

    typedef struct packed {
        logic [N_CTL_W-1:0] ctl;
        logic [N_W-1:0]     div;
    } ndiv_t;

    function automatic frame_t frame_push(frame_t f, logic b);
        logic [WORD_W-1:0] raw;
        raw = f;
        return frame_t'({raw[WORD_W-2:0], b});
    endfunction

    function automatic logic pd_of(logic [PAY_W-1:0] f);
        return f[PD_POS];
    endfunction

endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int NS = (STAGES < 2) ? 2 : STAGES;

    logic [NS-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[NS-2:0], d};
    end

    assign q = stg[NS-1];
endmodule

// File: rtl/sercfg_shifter.sv
module sercfg_shifter
    import sercfg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sclk_s,
    input  logic   sdat_s,
    input  logic   le_s,
    output frame_t frame,
    output logic   ld_pulse
);
    logic   sclk_d, le_d;
    logic   sclk_rise;
    frame_t sh_q;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign ld_pulse  = le_s & ~le_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            le_d   <= 1'b0;
            sh_q   <= '0;
        end else begin
            sclk_d <= sclk_s;
            le_d   <= le_s;
            if (sclk_rise) sh_q <= frame_push(sh_q, sdat_s);
        end
    end

    assign frame = sh_q;
endmodule

// File: rtl/sercfg_latch_bank.sv
module sercfg_latch_bank
    import sercfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_pulse,
    input  frame_t           frame,
    output ref_t             ref_q,
    output ndiv_t            n_q,
    output logic [PAY_W-1:0] func_q,
    output logic [PAY_W-1:0] init_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= '0;
            n_q    <= '0;
            func_q <= '0;
            init_q <= '0;
        end else if (ld_pulse) begin
            unique case (frame.sel)
                SEL_REF:  ref_q <= ref_t'(frame.pay);
                SEL_NDIV: n_q   <= ndiv_t'(frame.pay);
                SEL_FUNC: func_q <= frame.pay;
                SEL_INIT: begin
                    init_q <= frame.pay;
                    func_q <= frame.pay;
                end
            endcase
        end
    end
endmodule

// File: rtl/sercfg_bank.sv
module sercfg_bank
    import sercfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ser_clk,
    input  logic                 ser_data,
    input  logic                 ser_le,
    input  logic                 chip_en,
    output logic [REF_W-1:0]     ref_div,
    output logic [REF_CTL_W-1:0] ref_ctl,
    output logic [N_W-1:0]       n_div,
    output logic [N_CTL_W-1:0]   n_ctl,
    output logic [PAY_W-1:0]     func_word,
    output logic [PAY_W-1:0]     init_word,
    output logic                 pwr_up,
    output logic                 cp_hiz
);
    localparam int NPIN = 4;

    logic [NPIN-1:0] pins_s;
    logic            sclk_s, sdat_s, le_s, ce_s;
    frame_t          frame_q;
    logic            ld_pulse;
    ref_t            ref_q;
    ndiv_t           n_q;
    logic [PAY_W-1:0] func_q, init_q;

    sercfg_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({chip_en, ser_le, ser_data, ser_clk}),
        .q   (pins_s)
    );

    assign {ce_s, le_s, sdat_s, sclk_s} = pins_s;

    sercfg_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .sclk_s   (sclk_s),
        .sdat_s   (sdat_s),
        .le_s     (le_s),
        .frame    (frame_q),
        .ld_pulse (ld_pulse)
    );

    sercfg_latch_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .ld_pulse (ld_pulse),
        .frame    (frame_q),
        .ref_q    (ref_q),
        .n_q      (n_q),
        .func_q   (func_q),
        .init_q   (init_q)
    );

    assign ref_div   = ref_q.div;
    assign ref_ctl   = ref_q.ctl;
    assign n_div     = n_q.div;
    assign n_ctl     = n_q.ctl;
    assign func_word = func_q;
    assign init_word = init_q;
    assign pwr_up    = ce_s & ~pd_of(func_q);
    assign cp_hiz    = ~pwr_up;
endmodule

// File: rtl/sercfg_bank_chk.sv
module sercfg_bank_chk
    import sercfg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ld_pulse,
    input logic [SEL_W-1:0] ld_sel,
    input logic             chip_en,
    input logic             pwr_up,
    input logic [REF_W-1:0] ref_div,
    input logic [N_W-1:0]   n_div,
    input logic [PAY_W-1:0] func_word,
    input logic [PAY_W-1:0] init_word
);
    // R3
    ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ref_div) |-> ($past(ld_pulse) && $past(ld_sel) == 2'b00));

    // R4
    n_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(n_div) |-> ($past(ld_pulse) && $past(ld_sel) == 2'b01));

    // R5
    func_src_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(func_word) |-> ($past(ld_pulse) && $past(ld_sel[1])));

    // R6
    init_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_pulse && ld_sel == 2'b11) |=> (func_word == init_word));

    // R9
    ce_off_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(chip_en, 2) |-> !pwr_up);
endmodule

bind sercfg_bank sercfg_bank_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ld_pulse  (ld_pulse),
    .ld_sel    (frame_q.sel),
    .chip_en   (chip_en),
    .pwr_up    (pwr_up),
    .ref_div   (ref_div),
    .n_div     (n_div),
    .func_word (func_word),
    .init_word (init_word)
);

// File: tb/tb_sercfg_bank.sv
`timescale 1ns/1ps
module tb_sercfg_bank;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0, chip_en = 1'b1;
    logic [13:0] ref_div;
    logic [7:0]  ref_ctl;
    logic [12:0] n_div;
    logic [8:0]  n_ctl;
    logic [21:0] func_word, init_word;
    logic        pwr_up, cp_hiz;

    always #2 clk = ~clk;

    sercfg_bank dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .chip_en(chip_en), .ref_div(ref_div), .ref_ctl(ref_ctl),
        .n_div(n_div), .n_ctl(n_ctl), .func_word(func_word), .init_word(init_word),
        .pwr_up(pwr_up), .cp_hiz(cp_hiz)
    );

    typedef struct {
        string       tag;
        logic [13:0] rd;
        logic [7:0]  rc;
        logic [12:0] nd;
        logic [8:0]  nc;
        logic [21:0] fw;
        logic [21:0] iw;
        logic        pu;
        logic        hz;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    logic [13:0] m_rd = '0;
    logic [7:0]  m_rc = '0;
    logic [12:0] m_nd = '0;
    logic [8:0]  m_nc = '0;
    logic [21:0] m_fw = '0;
    logic [21:0] m_iw = '0;
    logic        m_ce = 1'b1;

    task automatic cmp(string tag, string nm, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, nm, act, expv);
        end
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(chk_ev);
            repeat (6) @(negedge clk);
            e = exp_q.pop_front();
            cmp(e.tag, "ref_div",   32'(ref_div),   32'(e.rd));
            cmp(e.tag, "ref_ctl",   32'(ref_ctl),   32'(e.rc));
            cmp(e.tag, "n_div",     32'(n_div),     32'(e.nd));
            cmp(e.tag, "n_ctl",     32'(n_ctl),     32'(e.nc));
            cmp(e.tag, "func_word", 32'(func_word), 32'(e.fw));
            cmp(e.tag, "init_word", 32'(init_word), 32'(e.iw));
            cmp(e.tag, "pwr_up",    32'(pwr_up),    32'(e.pu));
            cmp(e.tag, "cp_hiz",    32'(cp_hiz),    32'(e.hz));
        end
    end

    task automatic expect_now(string tag);
        exp_t e;
        e.tag = tag;
        e.rd = m_rd; e.rc = m_rc; e.nd = m_nd; e.nc = m_nc;
        e.fw = m_fw; e.iw = m_iw;
        e.pu = m_ce & ~m_fw[1];
        e.hz = ~e.pu;
        exp_q.push_back(e);
        -> chk_ev;
        repeat (12) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = v[i];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_le();
        ser_le = 1'b1;
        repeat (4) @(negedge clk);
        ser_le = 1'b0;
    endtask

    task automatic model_load(input logic [23:0] w);
        case (w[1:0])
            2'b00: begin m_rd = w[15:2]; m_rc = w[23:16]; end
            2'b01: begin m_nd = w[14:2]; m_nc = w[23:15]; end
            2'b10: m_fw = w[23:2];
            default: begin m_iw = w[23:2]; m_fw = w[23:2]; end
        endcase
    endtask

    task automatic write_word(input logic [23:0] w, input string tag);
        send_bits({8'h00, w}, 24);
        pulse_le();
        model_load(w);
        expect_now(tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        expect_now("R1 reset");

        write_word({8'hA5, 14'h2C3B, 2'b00}, "R3 ref load");
        write_word({9'h15A, 13'h1ABC, 2'b01}, "R4 R10 n load keeps ref");
        write_word({22'h155550, 2'b10}, "R5 func load keeps init");
        write_word({22'h0ABCD8, 2'b11}, "R6 init load mirrors func");
        write_word({8'h3C, 14'h0001, 2'b00}, "R10 ref reload keeps others");
        write_word({22'h3C0F0A, 2'b10}, "R8 power-down bit set");
        write_word({22'h3C0F08, 2'b10}, "R8 power-down bit cleared");

        chip_en = 1'b0; m_ce = 1'b0;
        expect_now("R9 chip enable low");
        write_word({22'h3C0F08, 2'b10}, "R9 chip enable low with func load");
        chip_en = 1'b1; m_ce = 1'b1;
        expect_now("R9 chip enable restored");

        send_bits(32'h3, 2);
        write_word({9'h0F1, 13'h0A55, 2'b01}, "R2 extra leading bits dropped");
        write_word({8'h01, 14'h2000, 2'b00}, "R2 MSB first ordering");

        ser_le = 1'b1;
        repeat (4) @(negedge clk);
        send_bits(32'h00FF_FFFF, 6);
        ser_le = 1'b0;
        repeat (4) @(negedge clk);
        expect_now("R7 clocks during load strobe");

        write_word({22'h2AAAA8, 2'b11}, "R6 second init load");

        repeat (10) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule